// File: doc/BRIEF.md
# Byte-Lane Width Bridge

The bridge sits between a bus master that issues either 8-bit or 16-bit accesses and a single target whose data path is either 8 or 16 bits wide. Both sides use a classic single-transfer handshake (cycle, strobe, write enable, byte address, data, acknowledge), and the target side also carries byte selects. A static flag, `tgt_wide`, tells the bridge how wide the target is. A per-access flag, `m_wide`, tells it how wide the master's request is. When the two widths agree, the request passes straight through. When they differ, the bridge either splits the access or narrows it, and it steers the bytes so that the master always sees a transfer of the width it asked for.

A 16-bit request to an 8-bit target becomes two back-to-back narrow cycles. The first goes to the even byte and the second to the odd byte, and the two read bytes are joined into one word before the master is acknowledged. An 8-bit request to a 16-bit target becomes one wide cycle. Its byte select is taken from address bit 0, and on an odd address the upper lane is moved onto the master's low byte.

The splitter is a two-state machine:
- `ST_IDLE` covers no activity, pass-through traffic and the first narrow cycle of a split.
- `ST_IDLE -> ST_UPPER` is taken when the first narrow cycle of a split is acknowledged. The low read byte is captured on the same edge.
- `ST_UPPER` drives the second narrow cycle.
- `ST_UPPER -> ST_IDLE` is taken when that cycle is acknowledged, or when the master withdraws its strobe.
- Reset forces `ST_IDLE` and clears the captured byte.

Top module: `bus_width_bridge`

## Requirements
- R1: When the master and target widths match, the access goes through with no added wait states: `m_ack` follows `t_ack` in the same cycle. In 8-on-8 mode, the address passes through unchanged, `t_sel` is 2'b01 and `t_wdat[15:8]` is zero. In 16-on-16 mode, address bit 0 is cleared, `t_sel` is 2'b11, and data passes through in both directions.
- R2: A 16-bit access to an 8-bit target produces exactly two target cycles, both with `t_sel` = 2'b01. The first goes to the master address with bit 0 forced to 0 and carries `m_wdat[7:0]` on `t_wdat[7:0]`. The second goes to the same address with bit 0 set to 1 and carries `m_wdat[15:8]` on `t_wdat[7:0]`.
- R3: During a split, `m_ack` rises only together with the second target acknowledge. The first acknowledge is absorbed.
- R4: A split read returns `{second-cycle t_rdat[7:0], first-cycle t_rdat[7:0]}` on `m_rdat` in the cycle of the master acknowledge.
- R5: An 8-bit access to a 16-bit target produces one target cycle with address bit 0 cleared. `t_sel` is 2'b01 for an even address and 2'b10 for an odd address.
- R6: In that narrowed cycle, `m_wdat[7:0]` is driven on both target byte lanes. The read byte comes from `t_rdat[15:8]` for an odd address and from `t_rdat[7:0]` for an even address, and it is returned on `m_rdat[7:0]`.
- R7: Every 8-bit access returns zero on `m_rdat[15:8]`. For an 8-bit target, `t_rdat[15:8]` is ignored.
- R8: The target strobe is high only while the master's cycle and strobe are both high, and `t_we` equals `m_we`.
- R9: Synchronous reset `rst` returns the splitter to idle, so the next split starts with the even byte. With no request pending, neither strobe nor acknowledge is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tgt_wide | input | 1 | Static target width: 1 = 16-bit, 0 = 8-bit |
| m_cyc | input | 1 | Master cycle |
| m_stb | input | 1 | Master strobe |
| m_we | input | 1 | Master write enable |
| m_wide | input | 1 | Access width: 1 = 16-bit, 0 = 8-bit |
| m_adr | input | AW | Master byte address |
| m_wdat | input | 16 | Master write data (8-bit accesses use [7:0]) |
| m_rdat | output | 16 | Read data to master |
| m_ack | output | 1 | Acknowledge to master |
| t_cyc | output | 1 | Target cycle |
| t_stb | output | 1 | Target strobe |
| t_we | output | 1 | Target write enable |
| t_adr | output | AW | Target byte address |
| t_sel | output | 2 | Target byte-lane selects |
| t_wdat | output | 16 | Target write data |
| t_rdat | input | 16 | Target read data (8-bit target uses [7:0]) |
| t_ack | input | 1 | Target acknowledge |

## Verification
Three things happen in the cycle that closes a split: the second target acknowledge becomes the master acknowledge, the stored low byte joins the live upper byte, and the machine falls back to idle. The bench provokes this by holding the master request high across consecutive split accesses with no idle cycle between them. It then requires a single master acknowledge with the correct assembled word, followed directly by an even-address first cycle for the next access. A second overlap comes from asserting reset in the middle of a split, after the first byte has been acknowledged; the next access is then judged on its target address and its returned word.

// File: rtl/bwb_pkg.sv
package bwb_pkg;

    typedef enum logic {
        ST_IDLE,
        ST_UPPER
    } split_st_t;

    typedef enum logic [1:0] {
        MD_PASS_N,
        MD_PASS_W,
        MD_SPLIT,
        MD_STEER
    } width_mode_t;

    function automatic width_mode_t pick_mode(input logic acc_wide, input logic dev_wide);
        unique case ({acc_wide, dev_wide})
            2'b00:   return MD_PASS_N;
            2'b11:   return MD_PASS_W;
            2'b10:   return MD_SPLIT;
            default: return MD_STEER;
        endcase
    endfunction

endpackage

// File: rtl/bwb_split_fsm.sv
module bwb_split_fsm
    import bwb_pkg::*;
#(
    parameter int LW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          split,
    input  logic          t_ack,
    input  logic [LW-1:0] rd_lane,
    output logic          upper,
    output logic [LW-1:0] lo_byte
);

    split_st_t st_q, st_d;
    logic      cap_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            lo_byte <= '0;
        end else begin
            st_q <= st_d;
            if (cap_lo) begin
                lo_byte <= rd_lane;
            end
        end
    end

    always_comb begin
        st_d   = st_q;
        cap_lo = 1'b0;
        unique case (st_q)
            ST_IDLE: begin
                if (req && split && t_ack) begin
                    st_d   = ST_UPPER;
                    cap_lo = 1'b1;
                end
            end
            ST_UPPER: begin
                if (!req || t_ack) begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    assign upper = (st_q == ST_UPPER);

    // R4: the low byte held for assembly is the one returned by the first narrow cycle.
    p_capture_lo_r4: assert property (@(posedge clk) disable iff (rst)
        (!upper && req && split && t_ack) |=> (upper && lo_byte == $past(rd_lane)));

    // R9: the cycle after reset is released, the machine is idle.
    p_idle_after_reset_r9: assert property (@(posedge clk)
        $past(rst) |-> !upper);

endmodule

// File: rtl/bwb_lane_steer.sv
module bwb_lane_steer
    import bwb_pkg::*;
#(
    parameter int LW = 8,
    localparam int DW = 2 * LW
) (
    input  width_mode_t   mode,
    input  logic          adr0,
    input  logic          upper,
    input  logic [LW-1:0] lo_byte,
    input  logic [DW-1:0] m_wdat,
    input  logic [DW-1:0] t_rdat,
    output logic          t_adr0,
    output logic [1:0]    t_sel,
    output logic [DW-1:0] t_wdat,
    output logic [DW-1:0] m_rdat
);

    logic [LW-1:0] rd_lane [2];
    logic [LW-1:0] wr_lo;
    logic [LW-1:0] wr_hi;

    for (genvar g = 0; g < 2; g++) begin : g_lane
        assign rd_lane[g] = t_rdat[g*LW +: LW];
    end

    assign wr_lo = m_wdat[LW-1:0];
    assign wr_hi = m_wdat[DW-1:LW];

    always_comb begin
        t_adr0 = 1'b0;
        t_sel  = 2'b01;
        t_wdat = '0;
        m_rdat = '0;
        unique case (mode)
            MD_PASS_N: begin
                t_adr0 = adr0;
                t_wdat = {{LW{1'b0}}, wr_lo};
                m_rdat = {{LW{1'b0}}, rd_lane[0]};
            end
            MD_PASS_W: begin
                t_sel  = 2'b11;
                t_wdat = m_wdat;
                m_rdat = t_rdat;
            end
            MD_SPLIT: begin
                t_adr0 = upper;
                t_wdat = {{LW{1'b0}}, (upper ? wr_hi : wr_lo)};
                m_rdat = {rd_lane[0], lo_byte};
            end
            MD_STEER: begin
                t_sel  = adr0 ? 2'b10 : 2'b01;
                t_wdat = {wr_lo, wr_lo};
                m_rdat = {{LW{1'b0}}, rd_lane[adr0]};
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/bus_width_bridge.sv
module bus_width_bridge
    import bwb_pkg::*;
#(
    parameter int AW = 20,
    parameter int LW = 8,
    localparam int DW = 2 * LW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tgt_wide,
    input  logic          m_cyc,
    input  logic          m_stb,
    input  logic          m_we,
    input  logic          m_wide,
    input  logic [AW-1:0] m_adr,
    input  logic [DW-1:0] m_wdat,
    output logic [DW-1:0] m_rdat,
    output logic          m_ack,
    output logic          t_cyc,
    output logic          t_stb,
    output logic          t_we,
    output logic [AW-1:0] t_adr,
    output logic [1:0]    t_sel,
    output logic [DW-1:0] t_wdat,
    input  logic [DW-1:0] t_rdat,
    input  logic          t_ack
);

    width_mode_t   mode;
    logic          req;
    logic          is_split;
    logic          upper;
    logic [LW-1:0] lo_byte;
    logic          t_adr0;

    assign mode     = pick_mode(m_wide, tgt_wide);
    assign req      = m_cyc && m_stb;
    assign is_split = (mode == MD_SPLIT);

    bwb_split_fsm #(.LW(LW)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .split   (is_split),
        .t_ack   (t_ack),
        .rd_lane (t_rdat[LW-1:0]),
        .upper   (upper),
        .lo_byte (lo_byte)
    );

    bwb_lane_steer #(.LW(LW)) u_steer (
        .mode    (mode),
        .adr0    (m_adr[0]),
        .upper   (upper),
        .lo_byte (lo_byte),
        .m_wdat  (m_wdat),
        .t_rdat  (t_rdat),
        .t_adr0  (t_adr0),
        .t_sel   (t_sel),
        .t_wdat  (t_wdat),
        .m_rdat  (m_rdat)
    );

    assign t_cyc = m_cyc;
    assign t_stb = req;
    assign t_we  = m_we;
    assign t_adr = {m_adr[AW-1:1], t_adr0};
    assign m_ack = req && t_ack && (!is_split || upper);

    // R8: no target strobe without a live master request
    p_stb_follows_r8: assert property (@(posedge clk) disable iff (rst)
        t_stb |-> (m_cyc && m_stb));

    // R2: an 8-bit target only ever sees the low lane selected
    p_narrow_sel_r2: assert property (@(posedge clk) disable iff (rst)
        (t_stb && !tgt_wide) |-> (t_sel == 2'b01));

    // R2: the second narrow cycle of a split goes to the odd byte
    p_upper_odd_r2: assert property (@(posedge clk) disable iff (rst)
        (t_stb && is_split && upper) |-> t_adr[0]);

    // R3: the first narrow acknowledge never reaches the master
    p_no_early_ack_r3: assert property (@(posedge clk) disable iff (rst)
        (req && is_split && !upper) |-> !m_ack);

    // R5: a narrowed access selects exactly one lane
    p_one_lane_r5: assert property (@(posedge clk) disable iff (rst)
        (t_stb && mode == MD_STEER) |-> ($countones(t_sel) == 1));

    // R1: the master acknowledge is never raised without a target acknowledge
    p_ack_source_r1: assert property (@(posedge clk) disable iff (rst)
        m_ack |-> t_ack);

endmodule

// File: tb/sim_bus_width_bridge.sv
`timescale 1ns/1ps
module sim_bus_width_bridge;

    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst;
    logic          tgt_wide;
    logic          m_cyc, m_stb, m_we, m_wide;
    logic [AW-1:0] m_adr;
    logic [15:0]   m_wdat;
    logic [15:0]   m_rdat;
    logic          m_ack;
    logic          t_cyc, t_stb, t_we;
    logic [AW-1:0] t_adr;
    logic [1:0]    t_sel;
    logic [15:0]   t_wdat;
    logic [15:0]   t_rdat;
    logic          t_ack;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc_n  = 0;

    always #2.5 clk = ~clk;

    bus_width_bridge #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .tgt_wide(tgt_wide),
        .m_cyc(m_cyc), .m_stb(m_stb), .m_we(m_we), .m_wide(m_wide),
        .m_adr(m_adr), .m_wdat(m_wdat), .m_rdat(m_rdat), .m_ack(m_ack),
        .t_cyc(t_cyc), .t_stb(t_stb), .t_we(t_we), .t_adr(t_adr),
        .t_sel(t_sel), .t_wdat(t_wdat), .t_rdat(t_rdat), .t_ack(t_ack)
    );

    // Behavioural target: byte memory, one wait state per cycle.
    logic [7:0] tmem [256];
    logic [7:0] refm [256];
    logic       ack_r;
    wire  [7:0] ta = t_adr[7:0];

    assign t_ack  = ack_r;
    assign t_rdat = tgt_wide ? {tmem[{ta[7:1], 1'b1}], tmem[{ta[7:1], 1'b0}]}
                             : {8'hEE, tmem[ta]};

    always @(posedge clk) begin
        if (rst) begin
            ack_r <= 1'b0;
        end else begin
            ack_r <= t_cyc && t_stb && !ack_r;
            if (t_cyc && t_stb && ack_r && t_we) begin
                if (tgt_wide) begin
                    if (t_sel[0]) tmem[{ta[7:1], 1'b0}] <= t_wdat[7:0];
                    if (t_sel[1]) tmem[{ta[7:1], 1'b1}] <= t_wdat[15:8];
                end else begin
                    tmem[ta] <= t_wdat[7:0];
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One master access; called right after a rising edge, returns right after one.
    task automatic access(input bit we, input bit mw, input logic [7:0] a, input logic [15:0] wd);
        int          ph = 0;
        int          guard = 0;
        bit          done = 0;
        bit          split = mw && !tgt_wide;
        logic        e_a0;
        logic [1:0]  e_sel;
        logic [15:0] e_wd;
        logic [15:0] e_rd;
        logic [7:0]  ev = {a[7:1], 1'b0};
        string       tg;
        tg = split ? "R2" : ((!mw && tgt_wide) ? "R5" : "R1");
        e_rd = mw ? {refm[ev | 8'd1], refm[ev]} : {8'h00, refm[a]};
        #1;
        m_cyc = 1'b1; m_stb = 1'b1; m_we = we; m_wide = mw;
        m_adr = {12'h000, a}; m_wdat = wd;
        while (!done && guard < 20) begin
            bit saw;
            @(negedge clk);
            e_a0  = split ? ph[0] : ((mw || tgt_wide) ? 1'b0 : a[0]);
            e_sel = !tgt_wide ? 2'b01 : (mw ? 2'b11 : (a[0] ? 2'b10 : 2'b01));
            if (!tgt_wide) e_wd = {8'h00, (split && ph == 1) ? wd[15:8] : wd[7:0]};
            else if (mw)   e_wd = wd;
            else           e_wd = {wd[7:0], wd[7:0]};
            chk(t_stb && t_cyc, {"R8 strobe ", tg}, {30'd0, t_cyc, t_stb}, 32'd3);
            chk(t_we == we, "R8 t_we", {31'd0, t_we}, {31'd0, we});
            chk(t_adr == {m_adr[AW-1:1], e_a0}, {tg, " t_adr"}, {12'd0, t_adr}, {12'd0, m_adr[AW-1:1], e_a0});
            chk(t_sel == e_sel, {tg, " t_sel"}, {30'd0, t_sel}, {30'd0, e_sel});
            if (we) chk(t_wdat == e_wd, {(!mw && tgt_wide) ? "R6" : tg, " t_wdat"}, {16'd0, t_wdat}, {16'd0, e_wd});
            chk(m_ack == (t_ack && (!split || ph == 1)), split ? "R3 m_ack" : "R1 m_ack",
                {31'd0, m_ack}, {31'd0, t_ack && (!split || ph == 1)});
            if (m_ack) begin
                done = 1;
                if (!we) begin
                    chk(m_rdat == e_rd, split ? "R4 m_rdat" : ((!mw && tgt_wide) ? "R6 m_rdat" : "R1 m_rdat"),
                        {16'd0, m_rdat}, {16'd0, e_rd});
                    if (!mw) chk(m_rdat[15:8] == 8'h00, "R7 upper zero", {24'd0, m_rdat[15:8]}, 32'd0);
                end
            end
            saw = t_ack;
            @(posedge clk);
            if (saw) ph++;
            guard++;
        end
        chk(done && ph == (split ? 2 : 1), split ? "R2 cycle count" : "R1 cycle count", ph, split ? 2 : 1);
        if (we) begin
            if (mw) begin refm[ev] = wd[7:0]; refm[ev | 8'd1] = wd[15:8]; end
            else refm[a] = wd[7:0];
        end
    endtask

    task automatic idle();
        #1 m_stb = 1'b0; m_cyc = 1'b0;
        @(posedge clk);
    endtask

    always @(posedge clk) begin
        cyc_n++;
        if (cyc_n > 100000) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc_n);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) begin
            tmem[i] = 8'(i * 37 + 5);
            refm[i] = 8'(i * 37 + 5);
        end
        rst = 1'b1; tgt_wide = 1'b0;
        m_cyc = 0; m_stb = 0; m_we = 0; m_wide = 0; m_adr = '0; m_wdat = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!t_stb && !m_ack, "R9 reset idle", {30'd0, t_stb, m_ack}, 32'd0);
        @(posedge clk);

        // R1 / R7: 8-bit target, 8-bit accesses
        access(1, 0, 8'h11, 16'h005A); idle();
        access(0, 0, 8'h11, 16'h0000); idle();
        access(0, 0, 8'h12, 16'h0000); idle();

        // R2 / R3 / R4: 16-bit accesses split over an 8-bit target, odd address forced even
        access(1, 1, 8'h30, 16'hCAFE); idle();
        access(0, 1, 8'h30, 16'h0000); idle();
        access(0, 1, 8'h31, 16'h0000); idle();
        access(0, 0, 8'h31, 16'h0000); idle();
        // back-to-back splits: final ack, assembly and return to idle share a cycle
        access(1, 1, 8'h44, 16'h1357);
        access(0, 1, 8'h44, 16'h0000);
        access(0, 1, 8'h46, 16'h0000); idle();

        // R1 / R5 / R6: 16-bit target
        #1 tgt_wide = 1'b1;
        @(posedge clk);
        access(1, 1, 8'h20, 16'h1234); idle();
        access(0, 1, 8'h21, 16'h0000); idle();
        access(0, 0, 8'h20, 16'h0000); idle();
        access(0, 0, 8'h21, 16'h0000); idle();
        access(1, 0, 8'h23, 16'h00A5); idle();
        access(1, 0, 8'h22, 16'h003C); idle();
        access(0, 1, 8'h22, 16'h0000); idle();

        // R9: reset in the middle of a split, after the low byte is accepted
        #1 tgt_wide = 1'b0;
        @(posedge clk);
        #1 m_cyc = 1; m_stb = 1; m_we = 1; m_wide = 1; m_adr = 20'h00050; m_wdat = 16'hBEEF;
        repeat (2) @(posedge clk);
        #1 rst = 1'b1; m_cyc = 0; m_stb = 0;
        refm[8'h50] = 8'hEF; // the first narrow write has completed at the target
        @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(!t_stb && !m_ack, "R9 after mid-split reset", {30'd0, t_stb, m_ack}, 32'd0);
        @(posedge clk);
        access(0, 1, 8'h50, 16'h0000); idle();

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule